// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a single pulse-width modulated output from an 8-bit period timer whose count is extended by a 2-bit sub-count. Together they form a 10-bit time base. A period register sets the timer's terminal value. The duty value is assembled from an 8-bit high-part register and a 2-bit field of a small control register. Both duty registers can be written at any moment. The value that is actually compared against the time base lives in a shadow register. That shadow is refreshed only when a period ends, so a duty change never produces a truncated or doubled pulse.

The time base advances once every 1, 4 or 16 input clocks, as chosen by the prescale select. The timer steps when the sub-count wraps. When the timer sits at the period value and the sub-count is at its top, the next advance starts a new period. At that step the timer and sub-count return to zero, the shadow takes the current duty value, and the output goes high unless that value is zero. The output drops on the step at which the time base reaches the shadow value. The mode field of the control register enables the block. A zero mode field holds the output low. The shadow value can be read back but cannot be written.

Top module: `dbuf_pwm_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `pwm_out` and `shadow_rd` are 0 after that edge. The timer, the sub-count and all configuration registers also return to zero.
- R2: The duty value is `{duty_hi_wdata, ctrl_wdata[5:4]}`, taking the high-part register as bits 9:2 and control bits 5:4 as bits 1:0. It appears unchanged on `shadow_rd` once a period has ended after both writes.
- R3: The prescale `psc_sel` is 2'b00 for 1 clock per time-base step, 2'b01 for 4 clocks and 2'b10 or 2'b11 for 16. A period lasts 4*(P+1)*prescale clocks, where P is the period register value, and the output rises once per period when the duty value D satisfies 0 < D < 4*(P+1).
- R4: For 0 < D < 4*(P+1), the output stays high for D*prescale clocks in each period.
- R5: With D = 0, the output is never set at a period start and stays low for the whole period.
- R6: With D >= 4*(P+1), the output stays high for the entire period, because the time base never reaches D.
- R7: A duty write leaves `shadow_rd` unchanged until the end of the current period, when the new value is loaded.
- R8: Writing a zero mode field (`ctrl_wdata[3:0]` = 0) forces `pwm_out` low no later than the second clock edge after the write edge. The output stays low while the mode field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psc_sel | input | 2 | Prescale select: 00 = 1, 01 = 4, 1x = 16 |
| period_we | input | 1 | Period register write strobe |
| period_wdata | input | 8 | Period register write data |
| duty_hi_we | input | 1 | Duty high-part write strobe |
| duty_hi_wdata | input | 8 | Duty bits 9:2 |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | [5:4] duty bits 1:0, [3:0] mode (nonzero enables) |
| pwm_out | output | 1 | Registered PWM level |
| shadow_rd | output | 10 | Read-back of the shadow duty register |

## Verification
The case that is hardest to reach from the ports is a duty write that lands inside a running period. The check must show that the shadow and the waveform keep the old value until the period ends and only then take the new one. The bench waits until the block is in steady state and changes only the high part of the duty value. It reads `shadow_rd` on the cycle right after the write edge, and again after a full period. It then measures the waveform. The sweep covers several period values and every prescale, and pushes the duty to 0, to the full period count and beyond it. High time and rising edges are counted over a window of exactly two periods, so the result does not depend on the window's phase.

// File: rtl/dbuf_pwm_pkg.sv
package dbuf_pwm_pkg;
  localparam int TMR_W  = 8;
  localparam int SUB_W  = 2;
  localparam int DIV_W  = 4;
  localparam int MODE_W = 4;
  localparam int TB_W   = TMR_W + SUB_W;

  typedef enum logic [1:0] {
    PSC_DIV1   = 2'd0,
    PSC_DIV4   = 2'd1,
    PSC_DIV16  = 2'd2,
    PSC_DIV16B = 2'd3
  } psc_sel_e;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
  parameter int TMR_W  = 8,
  parameter int SUB_W  = 2,
  parameter int MODE_W = 4,
  localparam int TB_W  = TMR_W + SUB_W,
  localparam int CTL_W = SUB_W + MODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             period_we,
  input  logic [TMR_W-1:0] period_wdata,
  input  logic             duty_hi_we,
  input  logic [TMR_W-1:0] duty_hi_wdata,
  input  logic             ctrl_we,
  input  logic [CTL_W-1:0] ctrl_wdata,
  output logic [TMR_W-1:0] period,
  output logic [TB_W-1:0]  duty_req,
  output logic             active
);
  logic [TMR_W-1:0] duty_hi_q;
  logic [CTL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      period    <= '0;
      duty_hi_q <= '0;
      ctrl_q    <= '0;
    end else begin
      if (period_we)  period    <= period_wdata;
      if (duty_hi_we) duty_hi_q <= duty_hi_wdata;
      if (ctrl_we)    ctrl_q    <= ctrl_wdata;
    end
  end

  // duty low bits sit directly above the mode field
  assign duty_req = {duty_hi_q, ctrl_q[CTL_W-1:MODE_W]};
  assign active   = |ctrl_q[MODE_W-1:0];
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  parameter int DIV_W = 4,
  localparam int TB_W = TMR_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       psc_sel,
  input  logic [TMR_W-1:0] period,
  output logic [TB_W-1:0]  tb,
  output logic [TB_W-1:0]  tb_next,
  output logic             step,
  output logic             wrap
);
  logic at_top;

  generate
    if (DIV_W == 0) begin : g_nodiv
      assign step = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] div_q;
      logic [DIV_W-1:0] div_lim;
      always_comb begin
        case (dbuf_pwm_pkg::psc_sel_e'(psc_sel))
          dbuf_pwm_pkg::PSC_DIV1: div_lim = '0;
          dbuf_pwm_pkg::PSC_DIV4: div_lim = DIV_W'(3);
          default:                div_lim = DIV_W'(15);
        endcase
      end
      assign step = (div_q >= div_lim);
      always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (step) div_q <= '0;
        else           div_q <= div_q + 1'b1;
      end
    end
  endgenerate

  assign at_top  = (tb[TB_W-1:SUB_W] == period) && (&tb[SUB_W-1:0]);
  assign wrap    = step && at_top;
  assign tb_next = at_top ? '0 : tb + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       tb <= '0;
    else if (step) tb <= tb_next;
  end
endmodule

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow #(
  parameter int TB_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wrap,
  input  logic [TB_W-1:0] duty_req,
  output logic [TB_W-1:0] shadow
);
  always_ff @(posedge clk) begin
    if (rst)       shadow <= '0;
    else if (wrap) shadow <= duty_req;
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int TB_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            step,
  input  logic            wrap,
  input  logic [TB_W-1:0] tb_next,
  input  logic [TB_W-1:0] duty_req,
  input  logic [TB_W-1:0] shadow,
  output logic            pwm_q
);
  always_ff @(posedge clk) begin
    if (rst)                            pwm_q <= 1'b0;
    else if (!active)                   pwm_q <= 1'b0;
    else if (wrap)                      pwm_q <= (duty_req != '0);
    else if (step && tb_next == shadow) pwm_q <= 1'b0;
  end
endmodule

// File: rtl/dbuf_pwm_gen.sv
module dbuf_pwm_gen #(
  parameter int TMR_W  = dbuf_pwm_pkg::TMR_W,
  parameter int SUB_W  = dbuf_pwm_pkg::SUB_W,
  parameter int DIV_W  = dbuf_pwm_pkg::DIV_W,
  parameter int MODE_W = dbuf_pwm_pkg::MODE_W,
  localparam int TB_W  = TMR_W + SUB_W,
  localparam int CTL_W = SUB_W + MODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       psc_sel,
  input  logic             period_we,
  input  logic [TMR_W-1:0] period_wdata,
  input  logic             duty_hi_we,
  input  logic [TMR_W-1:0] duty_hi_wdata,
  input  logic             ctrl_we,
  input  logic [CTL_W-1:0] ctrl_wdata,
  output logic             pwm_out,
  output logic [TB_W-1:0]  shadow_rd
);
  logic [TMR_W-1:0] period;
  logic [TB_W-1:0]  duty_req;
  logic             active;
  logic [TB_W-1:0]  tb;
  logic [TB_W-1:0]  tb_next;
  logic             step;
  logic             wrap;

  pwm_cfg_regs #(.TMR_W(TMR_W), .SUB_W(SUB_W), .MODE_W(MODE_W)) cfg_i (
    .clk(clk), .rst(rst),
    .period_we(period_we), .period_wdata(period_wdata),
    .duty_hi_we(duty_hi_we), .duty_hi_wdata(duty_hi_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .period(period), .duty_req(duty_req), .active(active)
  );

  pwm_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W), .DIV_W(DIV_W)) tbase_i (
    .clk(clk), .rst(rst), .psc_sel(psc_sel), .period(period),
    .tb(tb), .tb_next(tb_next), .step(step), .wrap(wrap)
  );

  pwm_duty_shadow #(.TB_W(TB_W)) shadow_i (
    .clk(clk), .rst(rst), .wrap(wrap), .duty_req(duty_req), .shadow(shadow_rd)
  );

  pwm_out_stage #(.TB_W(TB_W)) out_i (
    .clk(clk), .rst(rst), .active(active), .step(step), .wrap(wrap),
    .tb_next(tb_next), .duty_req(duty_req), .shadow(shadow_rd), .pwm_q(pwm_out)
  );
endmodule

// File: rtl/dbuf_pwm_chk.sv
module dbuf_pwm_chk #(
  parameter int TB_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            pwm_out,
  input logic [TB_W-1:0] shadow_rd,
  input logic            active,
  input logic            wrap,
  input logic [TB_W-1:0] tb
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!pwm_out && shadow_rd == '0));

  a_r8_inactive_low: assert property (@(posedge clk) disable iff (rst)
    !active |=> !pwm_out);

  a_r7_shadow_holds: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(shadow_rd));

  a_r5_no_rise_on_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> (shadow_rd != '0));

  a_r3_rise_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> (tb == '0));
endmodule

bind dbuf_pwm_gen dbuf_pwm_chk #(.TB_W(TB_W)) chk_i (
  .clk(clk), .rst(rst), .pwm_out(pwm_out), .shadow_rd(shadow_rd),
  .active(active), .wrap(wrap), .tb(tb)
);

// File: tb/dbuf_pwm_gen_tb_top.sv
`timescale 1ns/1ps
module dbuf_pwm_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] psc_sel = 2'b00;
  logic       period_we = 1'b0;
  logic [7:0] period_wdata = '0;
  logic       duty_hi_we = 1'b0;
  logic [7:0] duty_hi_wdata = '0;
  logic       ctrl_we = 1'b0;
  logic [5:0] ctrl_wdata = '0;
  logic       pwm_out;
  logic [9:0] shadow_rd;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbuf_pwm_gen dut_i (
    .clk(clk), .rst(rst), .psc_sel(psc_sel),
    .period_we(period_we), .period_wdata(period_wdata),
    .duty_hi_we(duty_hi_we), .duty_hi_wdata(duty_hi_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .pwm_out(pwm_out), .shadow_rd(shadow_rd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] ps);
    @(negedge clk);
    rst = 1'b1;
    psc_sel = ps;
    wait_clk(2);
    rst = 1'b0;
  endtask

  task automatic wr_period(input int p);
    @(negedge clk);
    period_we = 1'b1; period_wdata = 8'(p);
    @(negedge clk);
    period_we = 1'b0;
  endtask

  task automatic wr_hi(input int d);
    @(negedge clk);
    duty_hi_we = 1'b1; duty_hi_wdata = 8'(d >> 2);
    @(negedge clk);
    duty_hi_we = 1'b0;
  endtask

  task automatic wr_ctrl(input int d, input logic [3:0] mode);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = {2'(d), mode};
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  // samples 2*plen+1 negedges; counts high samples over the first 2*plen
  task automatic measure(input int plen, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0;
    prev = pwm_out;
    for (int i = 0; i < 2 * plen; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
      if (pwm_out && !prev) rises++;
      prev = pwm_out;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi, rises, plen, full, pscv, d;
    int prs[3] = '{0, 2, 5};
    int duties[6];

    // R1: reset state
    wait_clk(3);
    chk(pwm_out == 1'b0, "R1 pwm_out after reset", int'(pwm_out), 0);
    chk(shadow_rd == '0, "R1 shadow after reset", int'(shadow_rd), 0);
    rst = 1'b0;

    // sweep over period, prescale and duty corners
    foreach (prs[pi]) begin
      for (int ps = 0; ps < 3; ps++) begin
        pscv = (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
        full = 4 * (prs[pi] + 1);
        plen = full * pscv;
        duties[0] = 0;
        duties[1] = 1;
        duties[2] = full / 2 + 1;
        duties[3] = full - 1;
        duties[4] = full;
        duties[5] = full + 3;
        foreach (duties[di]) begin
          d = duties[di];
          do_reset(2'(ps));
          wr_period(prs[pi]);
          wr_hi(d);
          wr_ctrl(d & 3, 4'hC);
          wait_clk(2 * plen + 8);
          chk(shadow_rd == 10'(d), "R2 shadow equals assembled duty", int'(shadow_rd), d);
          measure(plen, hi, rises);
          if (d == 0) begin
            chk(hi == 0, "R5 zero duty high count", hi, 0);
            chk(rises == 0, "R5 zero duty rises", rises, 0);
          end else if (d >= full) begin
            chk(hi == 2 * plen, "R6 full duty high count", hi, 2 * plen);
            chk(rises == 0, "R6 full duty rises", rises, 0);
          end else begin
            chk(hi == 2 * d * pscv, "R4 high time", hi, 2 * d * pscv);
            chk(rises == 2, "R3 one rise per period", rises, 2);
          end
        end
      end
    end

    // R7: mid-period duty change is deferred to the period end
    do_reset(2'b00);
    wr_period(3);
    wr_hi(5);
    wr_ctrl(1, 4'hC);
    wait_clk(2 * 16 + 8);
    chk(shadow_rd == 10'd5, "R7 initial shadow", int'(shadow_rd), 5);
    wr_hi(9);
    chk(shadow_rd == 10'd5, "R7 shadow held after write", int'(shadow_rd), 5);
    wait_clk(16 + 2);
    chk(shadow_rd == 10'd9, "R7 shadow loaded at period end", int'(shadow_rd), 9);
    measure(16, hi, rises);
    chk(hi == 18, "R7 new duty in effect", hi, 18);

    // R8: zero mode field forces output low
    wr_ctrl(1, 4'h0);
    wait_clk(1);
    measure(16, hi, rises);
    chk(hi == 0, "R8 cleared mode high count", hi, 0);
    chk(pwm_out == 1'b0, "R8 output low", int'(pwm_out), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule